// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit with Signed and Unsigned Ordering

This block is the purely combinational integer calculation stage of a small load/store style datapath. Two data words, A and B, a shift count and a four-bit operation code come in. One data word and a flag that marks an all-zero result go out. It has no clock and no storage. Any register that captures the result belongs to the surrounding pipeline.

The supported operations fall into four groups:
- **Arithmetic:** wrapping addition and subtraction in two's complement.
- **Bitwise:** AND, OR, XOR and NOR. NOR against a zero word gives a bitwise inversion.
- **Ordering tests:** two less-than tests, one that reads the operands as signed numbers and one that reads them as unsigned magnitudes. Each returns the word 1 or the word 0.
- **Shifts of operand B:** left with zero fill, right with zero fill, and right with copies of the sign bit. The shift count can be any value from 0 to one less than the word width.

Branch-on-equal logic can use the zero flag after a subtraction. The data width is a parameter, 32 by default. A second parameter selects how the ordering tests are built.

Top module: `int_alu`

## Requirements
- R1: Operation code 0 (add) gives A + B modulo 2^DATA_W. No overflow is signalled.
- R2: Operation code 1 (subtract) gives A + ~B + 1 modulo 2^DATA_W, which is A minus B in two's complement.
- R3: Operation codes 2, 3 and 4 give the bitwise AND, OR and XOR of A and B.
- R4: Operation code 5 gives ~(A | B). When B is zero, the result is ~A.
- R5: Operation code 6 (signed less-than) gives 1 when A < B as two's-complement numbers and 0 otherwise. For example, A = all ones with B = 1 gives 1.
- R6: Operation code 7 (unsigned less-than) gives 1 when A < B as unsigned magnitudes and 0 otherwise. For example, A = all ones with B = 1 gives 0.
- R7: Operation code 8 shifts B left by the shift count and fills the vacated low bits with zeros.
- R8: Operation code 9 shifts B right by the shift count and fills the vacated high bits with zeros.
- R9: Operation code 10 shifts B right by the shift count and fills the vacated high bits with copies of B's top bit.
- R10: The zero flag is 1 exactly when every bit of the result is 0.
- R11: Operation codes 11 to 15 give a result of 0, so the zero flag is 1.
- R12: Every shift count from 0 to DATA_W-1 is honoured. A count of 0 passes B through unchanged for all three shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code; the values are listed in the requirements |
| a_i | input | DATA_W | First operand |
| b_i | input | DATA_W | Second operand, also the word that is shifted |
| shamt_i | input | log2(DATA_W) | Shift count |
| result_o | output | DATA_W | Result word |
| zero_o | output | 1 | High when the result is all zeros |

## Verification
The checker assumes that the inputs hold steady until the combinational paths have settled. It also assumes that the operation code is a defined four-bit value, so every code, including the unused ones, maps onto exactly one result path. The bench meets these assumptions by changing inputs only on the falling clock edge and sampling one nanosecond later, with nothing else in flight. The bench also sweeps the operation code over all sixteen values and the shift count over its full range. As a result, no input outside the assumed range is ever presented.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OPC_ADD  = 4'd0,
      OPC_SUB  = 4'd1,
      OPC_AND  = 4'd2,
      OPC_OR   = 4'd3,
      OPC_XOR  = 4'd4,
      OPC_NOR  = 4'd5,
      OPC_SLT  = 4'd6,
      OPC_SLTU = 4'd7,
      OPC_SLL  = 4'd8,
      OPC_SRL  = 4'd9,
      OPC_SRA  = 4'd10
   } alu_op_e;

   typedef enum logic [1:0] {
      SH_LEFT  = 2'd0,
      SH_RLOG  = 2'd1,
      SH_RARI  = 2'd2
   } shift_mode_e;
endpackage

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              sub_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              carry_o,
   output logic              ovf_o
);
   logic [DATA_W-1:0] b_eff;
   logic [DATA_W:0]   wide;

   assign b_eff = sub_i ? ~b_i : b_i;
   assign wide  = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
   assign sum_o   = wide[DATA_W-1:0];
   assign carry_o = wide[DATA_W];
   assign ovf_o   = (a_i[DATA_W-1] == b_eff[DATA_W-1]) &&
                    (sum_o[DATA_W-1] != a_i[DATA_W-1]);
endmodule

// File: rtl/int_alu_cmp.sv
module int_alu_cmp #(
   parameter int DATA_W         = 32,
   parameter bit CMP_FROM_ADDER = 1'b1
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [DATA_W-1:0] diff_i,
   input  logic              carry_i,
   input  logic              ovf_i,
   output logic              lt_s_o,
   output logic              lt_u_o
);
   generate
      if (CMP_FROM_ADDER) begin : g_shared
         // no borrow out of A + ~B + 1 means A >= B unsigned
         assign lt_u_o = ~carry_i;
         assign lt_s_o = diff_i[DATA_W-1] ^ ovf_i;
      end else begin : g_direct
         logic unused_w;
         assign unused_w = ^{diff_i, carry_i, ovf_i};
         assign lt_u_o = a_i < b_i;
         assign lt_s_o = $signed(a_i) < $signed(b_i);
      end
   endgenerate
endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic #(
   parameter int DATA_W = 32
) (
   input  logic [1:0]        fn_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] y_o
);
   always_comb begin
      unique case (fn_i)
         2'd0:    y_o = a_i & b_i;
         2'd1:    y_o = a_i | b_i;
         2'd2:    y_o = a_i ^ b_i;
         default: y_o = ~(a_i | b_i);
      endcase
   end
endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift
   import int_alu_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int SH_W  = $clog2(DATA_W)
) (
   input  shift_mode_e       mode_i,
   input  logic [DATA_W-1:0] val_i,
   input  logic [SH_W-1:0]   amt_i,
   output logic [DATA_W-1:0] y_o
);
   logic [DATA_W-1:0] lft [0:SH_W];
   logic [DATA_W-1:0] rgt [0:SH_W];
   logic              fill;

   assign fill   = (mode_i == SH_RARI) ? val_i[DATA_W-1] : 1'b0;
   assign lft[0] = val_i;
   assign rgt[0] = val_i;

   generate
      for (genvar k = 0; k < SH_W; k++) begin : g_stage
         localparam int S = 2 ** k;
         assign lft[k+1] = amt_i[k] ? {lft[k][DATA_W-1-S:0], {S{1'b0}}} : lft[k];
         assign rgt[k+1] = amt_i[k] ? {{S{fill}}, rgt[k][DATA_W-1:S]}    : rgt[k];
      end
   endgenerate

   assign y_o = (mode_i == SH_LEFT) ? lft[SH_W] : rgt[SH_W];
endmodule

// File: rtl/int_alu.sv
module int_alu
   import int_alu_pkg::*;
#(
   parameter int DATA_W         = 32,
   parameter bit CMP_FROM_ADDER = 1'b1,
   localparam int SH_W          = $clog2(DATA_W)
) (
   input  logic [OP_W-1:0]   op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [SH_W-1:0]   shamt_i,
   output logic [DATA_W-1:0] result_o,
   output logic              zero_o
);
   generate
      if (DATA_W < 4 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("int_alu: DATA_W must be a power of two, at least 4");
      end
   endgenerate

   alu_op_e           op;
   logic              sub_sel;
   logic [DATA_W-1:0] sum, logic_y, shift_y;
   logic              carry, ovf, lt_s, lt_u;
   logic [1:0]        logic_fn;
   shift_mode_e       sh_mode;

   assign op      = alu_op_e'(op_i);
   assign sub_sel = (op == OPC_SUB) || (op == OPC_SLT) || (op == OPC_SLTU);

   always_comb begin
      unique case (op)
         OPC_AND: logic_fn = 2'd0;
         OPC_OR:  logic_fn = 2'd1;
         OPC_XOR: logic_fn = 2'd2;
         default: logic_fn = 2'd3;
      endcase
      unique case (op)
         OPC_SRL: sh_mode = SH_RLOG;
         OPC_SRA: sh_mode = SH_RARI;
         default: sh_mode = SH_LEFT;
      endcase
   end

   int_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
      .a_i(a_i), .b_i(b_i), .sub_i(sub_sel),
      .sum_o(sum), .carry_o(carry), .ovf_o(ovf)
   );

   int_alu_cmp #(.DATA_W(DATA_W), .CMP_FROM_ADDER(CMP_FROM_ADDER)) u_cmp (
      .a_i(a_i), .b_i(b_i), .diff_i(sum), .carry_i(carry), .ovf_i(ovf),
      .lt_s_o(lt_s), .lt_u_o(lt_u)
   );

   int_alu_logic #(.DATA_W(DATA_W)) u_logic (
      .fn_i(logic_fn), .a_i(a_i), .b_i(b_i), .y_o(logic_y)
   );

   int_alu_shift #(.DATA_W(DATA_W)) u_shift (
      .mode_i(sh_mode), .val_i(b_i), .amt_i(shamt_i), .y_o(shift_y)
   );

   always_comb begin
      case (op)
         OPC_ADD, OPC_SUB:                   result_o = sum;
         OPC_AND, OPC_OR, OPC_XOR, OPC_NOR:  result_o = logic_y;
         OPC_SLT:                            result_o = {{(DATA_W-1){1'b0}}, lt_s};
         OPC_SLTU:                           result_o = {{(DATA_W-1){1'b0}}, lt_u};
         OPC_SLL, OPC_SRL, OPC_SRA:          result_o = shift_y;
         default:                            result_o = '0;
      endcase
   end

   assign zero_o = ~|result_o;
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
   import int_alu_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int SH_W  = $clog2(DATA_W)
) (
   input logic [OP_W-1:0]   op_i,
   input logic [DATA_W-1:0] a_i,
   input logic [DATA_W-1:0] b_i,
   input logic [SH_W-1:0]   shamt_i,
   input logic [DATA_W-1:0] result_o,
   input logic              zero_o
);
   logic [DATA_W-1:0] low_mask;
   assign low_mask = (DATA_W'(1) << shamt_i) - DATA_W'(1);

   always_comb begin
      if (op_i == OPC_ADD)
         assert_add_inverse_R1: assert (result_o - b_i == a_i) else $error("add inverse");
      if (op_i == OPC_SUB)
         assert_sub_inverse_R2: assert (result_o + b_i == a_i) else $error("sub inverse");
      if (op_i == OPC_AND)
         assert_and_subset_R3: assert (((result_o & ~a_i) | (result_o & ~b_i)) == '0) else $error("and subset");
      if (op_i == OPC_NOR)
         assert_nor_disjoint_R4: assert ((result_o & (a_i | b_i)) == '0 && (result_o | a_i | b_i) == '1)
            else $error("nor partition");
      if (op_i == OPC_SLT)
         assert_slt_bool_R5: assert ((result_o >> 1) == '0) else $error("slt not boolean");
      if (op_i == OPC_SLTU)
         assert_sltu_bool_R6: assert ((result_o >> 1) == '0 && (a_i != b_i || result_o == '0))
            else $error("sltu not boolean");
      if (op_i == OPC_SLL)
         assert_sll_lowzero_R7: assert ((result_o & low_mask) == '0) else $error("sll fill");
      if (op_i == OPC_SRL && shamt_i != '0)
         assert_srl_topzero_R8: assert (result_o[DATA_W-1] == 1'b0) else $error("srl fill");
      if (op_i == OPC_SRA)
         assert_sra_sign_R9: assert (result_o[DATA_W-1] == b_i[DATA_W-1]) else $error("sra fill");
      if (op_i == OPC_SUB && a_i == b_i)
         assert_zero_on_equal_R10: assert (zero_o) else $error("zero flag");
      if (op_i > OPC_SRA)
         assert_unused_clear_R11: assert (result_o == '0 && zero_o) else $error("unused code");
      if ((op_i == OPC_SLL || op_i == OPC_SRL || op_i == OPC_SRA) && shamt_i == '0)
         assert_shift_zero_pass_R12: assert (result_o == b_i) else $error("shift by zero");
   end
endmodule

bind int_alu int_alu_chk #(.DATA_W(DATA_W)) u_chk (
   .op_i(op_i), .a_i(a_i), .b_i(b_i), .shamt_i(shamt_i),
   .result_o(result_o), .zero_o(zero_o)
);

// File: tb/int_alu_tb_top.sv
module int_alu_tb_top;
   localparam int W  = 32;
   localparam int SW = 5;

   logic          clk = 1'b0;
   logic [3:0]    op;
   logic [W-1:0]  a, b, res;
   logic [SW-1:0] sh;
   logic          zf;
   int            checks = 0;
   int            errors = 0;
   bit            done = 1'b0;

   always #4 clk = ~clk;

   int_alu #(.DATA_W(W)) dut_i (
      .op_i(op), .a_i(a), .b_i(b), .shamt_i(sh),
      .result_o(res), .zero_o(zf)
   );

   task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h (op=%0d a=%h b=%h sh=%0d)", req, got, exp, op, a, b, sh);
      end
   endtask

   task automatic apply(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y,
                        input logic [SW-1:0] s);
      @(negedge clk);
      op = o; a = x; b = y; sh = s;
      #1;
   endtask

   task automatic t_add();
      apply(4'd0, 32'h0000_0005, 32'h0000_0007, 0); check("R1", res, 32'd12);
      apply(4'd0, 32'hFFFF_FFFF, 32'h0000_0002, 0); check("R1 wrap", res, 32'h0000_0001);
      apply(4'd0, 32'h7FFF_FFFF, 32'h0000_0001, 0); check("R1 no trap", res, 32'h8000_0000);
   endtask

   task automatic t_sub();
      apply(4'd1, 32'd10, 32'd3, 0); check("R2", res, 32'd7);
      apply(4'd1, 32'd0, 32'd2, 0);  check("R2 negate", res, ~32'd2 + 32'd1);
      apply(4'd1, 32'h8000_0000, 32'd1, 0); check("R2 wrap", res, 32'h7FFF_FFFF);
   endtask

   task automatic t_logic();
      logic [W-1:0] x = 32'h0000_3C00, y = 32'h0000_0DC0;
      apply(4'd2, x, y, 0); check("R3 and", res, x & y);
      apply(4'd3, x, y, 0); check("R3 or",  res, x | y);
      apply(4'd4, x, y, 0); check("R3 xor", res, x ^ y);
   endtask

   task automatic t_nor();
      apply(4'd5, 32'h0000_3C00, 32'd0, 0); check("R4 not", res, 32'hFFFF_C3FF);
      apply(4'd5, 32'hF0F0_0000, 32'h0F0F_00FF, 0); check("R4 nor", res, 32'h0000_FF00);
   endtask

   task automatic t_slt();
      apply(4'd6, 32'hFFFF_FFFF, 32'd1, 0); check("R5 -1<1", res, 32'd1);
      apply(4'd6, 32'd1, 32'hFFFF_FFFF, 0); check("R5 1<-1", res, 32'd0);
      apply(4'd6, 32'h8000_0000, 32'h7FFF_FFFF, 0); check("R5 min<max", res, 32'd1);
      apply(4'd6, 32'd9, 32'd9, 0); check("R5 equal", res, 32'd0);
      for (int i = 0; i < 20; i++) begin
         logic [W-1:0] x = 32'h1357_9BDF * (i + 1) ^ 32'hA5A5_0000;
         logic [W-1:0] y = 32'h89AB_CDEF * (i + 3);
         apply(4'd6, x, y, 0);
         check("R5 sweep", res, ($signed(x) < $signed(y)) ? 32'd1 : 32'd0);
      end
   endtask

   task automatic t_sltu();
      apply(4'd7, 32'hFFFF_FFFF, 32'd1, 0); check("R6 max>1", res, 32'd0);
      apply(4'd7, 32'd1, 32'hFFFF_FFFF, 0); check("R6 1<max", res, 32'd1);
      apply(4'd7, 32'd4, 32'd4, 0); check("R6 equal", res, 32'd0);
      for (int i = 0; i < 20; i++) begin
         logic [W-1:0] x = 32'h2468_ACE1 * (i + 5);
         logic [W-1:0] y = 32'hFEDC_BA98 ^ (32'h0101_0101 * i);
         apply(4'd7, x, y, 0);
         check("R6 sweep", res, (x < y) ? 32'd1 : 32'd0);
      end
   endtask

   task automatic t_shifts();
      logic [W-1:0] pos = 32'h4C3B_2A19, neg = 32'hB1C2_D3E4;
      for (int s = 0; s < 32; s++) begin
         apply(4'd8, 32'd0, neg, SW'(s)); check("R7 sll", res, neg << s);
         apply(4'd9, 32'd0, neg, SW'(s)); check("R8 srl", res, neg >> s);
         apply(4'd10, 32'd0, neg, SW'(s)); check("R9 sra neg", res, W'($signed(neg) >>> s));
         apply(4'd10, 32'd0, pos, SW'(s)); check("R9 sra pos", res, W'($signed(pos) >>> s));
      end
      apply(4'd8, 32'd0, neg, 0); check("R12 sll 0", res, neg);
      apply(4'd9, 32'd0, neg, 0); check("R12 srl 0", res, neg);
      apply(4'd10, 32'd0, neg, 0); check("R12 sra 0", res, neg);
      apply(4'd10, 32'd0, 32'h8000_0000, 5'd31); check("R12 sra 31", res, 32'hFFFF_FFFF);
      apply(4'd9, 32'd0, 32'h8000_0000, 5'd31); check("R12 srl 31", res, 32'd1);
   endtask

   task automatic t_zero();
      apply(4'd1, 32'h1234_5678, 32'h1234_5678, 0); check("R10 sub equal", W'(zf), 32'd1);
      apply(4'd1, 32'h1234_5678, 32'h1234_5679, 0); check("R10 sub differ", W'(zf), 32'd0);
      apply(4'd2, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 0); check("R10 and disjoint", W'(zf), 32'd1);
      apply(4'd7, 32'hFFFF_FFFF, 32'd1, 0); check("R10 sltu false", W'(zf), 32'd1);
   endtask

   task automatic t_unused();
      for (int o = 11; o < 16; o++) begin
         apply(4'(o), 32'hDEAD_BEEF, 32'hCAFE_F00D, 5'd3);
         check("R11 result", res, 32'd0);
         check("R11 zero", W'(zf), 32'd1);
      end
   endtask

   initial begin
      op = 4'd0; a = '0; b = '0; sh = '0;
      #1;
      check("R10 idle", {res[W-2:0], zf}, 32'd1);
      t_add();
      t_sub();
      t_logic();
      t_nor();
      t_slt();
      t_sltu();
      t_shifts();
      t_zero();
      t_unused();
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule